// File: doc/BRIEF.md
# Game Port Button and Position Event Controller

This block sits behind a byte-wide register bus and reports the state of a two-device analog game port. It samples four button inputs and takes in the finished X/Y counts of devices A and B. Each device's counts arrive as 16-bit values, qualified by a one-cycle ready strobe. The analog timing that produces those counts lies outside the block.

In legacy mode, software can only poll the synchronized button levels and the captured positions. The interrupt request stays low. In enhanced mode, the block latches button edges and position-ready events into a sticky status register. Software clears that register by writing ones to it. For the buttons, a polarity register picks rising or falling edges, one bit per button. A separate enable register selects which latched sources drive the single interrupt request.

Top module: `gameport_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low.
- R2: Offset 0h is the control register. Bit 0 selects the mode (1 = enhanced, 0 = legacy). It reads back as written, and bits 7:1 read 0.
- R3: Offset 1h reads the live button levels in bits 3:0, after a two-stage synchronizer, with bits 7:4 at 0. A write to offset 1h changes nothing.
- R4: In enhanced mode, an edge on button k sets status bit k (offset 2h). Bit k of the polarity register (offset 4h) selects the edge: 1 selects the rising edge, 0 the falling edge.
- R5: In enhanced mode, a position-ready strobe sets status bit 4 for device A or status bit 5 for device B.
- R6: Writing to offset 2h clears each status bit whose write-data bit is 1. A 0 in the write data leaves the bit unchanged.
- R7: When an event and a write-one clear hit the same status bit in the same cycle, the bit ends up set.
- R8: `irq` is high, one cycle after the status changes, exactly when the block is in enhanced mode and the status register ANDed with the enable register (offset 3h, bits 5:0 in the same bit order as the status) is non-zero. It stays high until software clears the status bits.
- R9: In legacy mode, no status bit gets set and `irq` stays low, whatever the status and enable registers hold.
- R10: A ready strobe captures that device's X and Y values, and the held values do not change until the next strobe. Offsets 8h–Fh read the held values: bit 2 of the address selects the device (0 = A, 1 = B), bit 1 selects the axis (0 = X, 1 = Y), and bit 0 selects the byte (0 = low, 1 = high).
- R11: Read data is registered. It appears the cycle after `bus_rd`, and it holds its value while no read is issued. Offsets 5h–7h read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register offset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| btn_in | input | 4 | Asynchronous button levels |
| pos_a_x | input | 16 | Device A X count |
| pos_a_y | input | 16 | Device A Y count |
| pos_a_rdy | input | 1 | Device A counts valid (one-cycle strobe) |
| pos_b_x | input | 16 | Device B X count |
| pos_b_y | input | 16 | Device B Y count |
| pos_b_rdy | input | 1 | Device B counts valid (one-cycle strobe) |
| irq | output | 1 | Interrupt request, level |

## Verification
The properties assume that `bus_rd` and `bus_wr` are never active together, and that each ready strobe lasts one cycle. They also assume that the bus address and write data are stable while a strobe is active. The stimulus drives every bus access from a task that raises exactly one strobe for one cycle. Button changes are spaced several cycles apart, so each edge clears the synchronizer before the next stimulus arrives. The only deliberate overlap is the directed case in which a ready strobe and a clearing write share a cycle.

// File: rtl/gp_pkg.sv
package gp_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] ADR_LIVE = 4'h1;
  localparam logic [ADDR_W-1:0] ADR_EVT  = 4'h2;
  localparam logic [ADDR_W-1:0] ADR_IEN  = 4'h3;
  localparam logic [ADDR_W-1:0] ADR_POL  = 4'h4;
endpackage

// File: rtl/gp_btn_edge.sv
module gp_btn_edge #(
  parameter int NBTN        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NBTN-1:0] btn_raw,
  input  logic [NBTN-1:0] pol,
  output logic [NBTN-1:0] level,
  output logic [NBTN-1:0] edge_hit
);
  localparam int LAST = SYNC_STAGES - 1;

  for (genvar i = 0; i < NBTN; i++) begin : g_btn
    logic [SYNC_STAGES-1:0] chain;
    logic                   prev;

    always_ff @(posedge clk) begin
      if (rst) begin
        chain <= '0;
        prev  <= 1'b0;
      end else begin
        chain <= {chain[SYNC_STAGES-2:0], btn_raw[i]};
        prev  <= chain[LAST];
      end
    end

    assign level[i]    = chain[LAST];
    assign edge_hit[i] = pol[i] ? (chain[LAST] & ~prev) : (~chain[LAST] & prev);
  end
endmodule

// File: rtl/gp_pos_hold.sv
module gp_pos_hold #(
  parameter int POS_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rdy,
  input  logic [POS_W-1:0] x_in,
  input  logic [POS_W-1:0] y_in,
  output logic [POS_W-1:0] x_q,
  output logic [POS_W-1:0] y_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      x_q <= '0;
      y_q <= '0;
    end else if (rdy) begin
      x_q <= x_in;
      y_q <= y_in;
    end
  end
endmodule

// File: rtl/gp_evt_status.sv
module gp_evt_status #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] stat_q
);
  // a set arriving with a clear of the same bit keeps the bit
  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= (stat_q & ~clr) | set;
  end
endmodule

// File: rtl/gameport_irq_ctrl.sv
module gameport_irq_ctrl
  import gp_pkg::*;
#(
  parameter int NBTN        = 4,
  parameter int POS_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NBTN-1:0]   btn_in,
  input  logic [POS_W-1:0]  pos_a_x,
  input  logic [POS_W-1:0]  pos_a_y,
  input  logic              pos_a_rdy,
  input  logic [POS_W-1:0]  pos_b_x,
  input  logic [POS_W-1:0]  pos_b_y,
  input  logic              pos_b_rdy,
  output logic              irq
);
  localparam int NDEV = 2;
  localparam int NSRC = NBTN + NDEV;

  logic              mode_q;
  logic [NSRC-1:0]   ien_q;
  logic [NBTN-1:0]   pol_q;
  logic [NSRC-1:0]   evt_q;
  logic [NSRC-1:0]   evt_set;
  logic [NSRC-1:0]   evt_clr;
  logic [NBTN-1:0]   btn_level;
  logic [NBTN-1:0]   btn_hit;
  logic [NDEV-1:0]   rdy_in;
  logic [POS_W-1:0]  x_in   [NDEV];
  logic [POS_W-1:0]  y_in   [NDEV];
  logic [POS_W-1:0]  x_hold [NDEV];
  logic [POS_W-1:0]  y_hold [NDEV];
  logic [DATA_W-1:0] rd_mux;
  logic [POS_W-1:0]  pos_word;

  assign x_in[0] = pos_a_x;
  assign y_in[0] = pos_a_y;
  assign x_in[1] = pos_b_x;
  assign y_in[1] = pos_b_y;
  assign rdy_in  = {pos_b_rdy, pos_a_rdy};

  gp_btn_edge #(.NBTN(NBTN), .SYNC_STAGES(SYNC_STAGES)) u_btn (
    .clk      (clk),
    .rst      (rst),
    .btn_raw  (btn_in),
    .pol      (pol_q),
    .level    (btn_level),
    .edge_hit (btn_hit)
  );

  for (genvar d = 0; d < NDEV; d++) begin : g_dev
    gp_pos_hold #(.POS_W(POS_W)) u_hold (
      .clk  (clk),
      .rst  (rst),
      .rdy  (rdy_in[d]),
      .x_in (x_in[d]),
      .y_in (y_in[d]),
      .x_q  (x_hold[d]),
      .y_q  (y_hold[d])
    );
  end

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 1'b0;
      ien_q  <= '0;
      pol_q  <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        ADR_CTRL: mode_q <= bus_wdata[0];
        ADR_IEN:  ien_q  <= bus_wdata[NSRC-1:0];
        ADR_POL:  pol_q  <= bus_wdata[NBTN-1:0];
        default:  ;
      endcase
    end
  end

  // events only latch in enhanced mode
  assign evt_set = mode_q ? {rdy_in, btn_hit} : '0;
  assign evt_clr = (bus_wr && bus_addr == ADR_EVT) ? bus_wdata[NSRC-1:0] : '0;

  gp_evt_status #(.W(NSRC)) u_evt (
    .clk    (clk),
    .rst    (rst),
    .set    (evt_set),
    .clr    (evt_clr),
    .stat_q (evt_q)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= mode_q & (|(evt_q & ien_q));
  end

  // read path: address bit 2 = device, bit 1 = axis, bit 0 = byte
  assign pos_word = bus_addr[1] ? y_hold[bus_addr[2]] : x_hold[bus_addr[2]];

  always_comb begin
    rd_mux = '0;
    if (bus_addr[3]) begin
      rd_mux = pos_word[{bus_addr[0], 3'b000} +: DATA_W];
    end else begin
      case (bus_addr)
        ADR_CTRL: rd_mux[0]        = mode_q;
        ADR_LIVE: rd_mux[NBTN-1:0] = btn_level;
        ADR_EVT:  rd_mux[NSRC-1:0] = evt_q;
        ADR_IEN:  rd_mux[NSRC-1:0] = ien_q;
        ADR_POL:  rd_mux[NBTN-1:0] = pol_q;
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/gp_irq_checker.sv
module gp_irq_checker #(
  parameter int NSRC = 6
) (
  input logic            clk,
  input logic            rst,
  input logic [3:0]      bus_addr,
  input logic            bus_rd,
  input logic            bus_wr,
  input logic [7:0]      bus_wdata,
  input logic [7:0]      bus_rdata,
  input logic            irq,
  input logic            mode_q,
  input logic [NSRC-1:0] ien_q,
  input logic [NSRC-1:0] evt_q,
  input logic [NSRC-1:0] evt_set
);
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 4'h2) |=> ((evt_q & $past(bus_wdata[NSRC-1:0] & ~evt_set)) == '0)); // R6

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
    (|evt_set) |=> ((evt_q & $past(evt_set)) == $past(evt_set))); // R7

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(mode_q && (|(evt_q & ien_q)))); // R8

  AST_LEGACY_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
    !mode_q |=> !irq); // R9

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata)); // R11
endmodule

bind gameport_irq_ctrl gp_irq_checker #(.NSRC(NSRC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .mode_q    (mode_q),
  .ien_q     (ien_q),
  .evt_q     (evt_q),
  .evt_set   (evt_set)
);

// File: tb/sim_gameport_irq_ctrl.sv
`timescale 1ns/1ps
module sim_gameport_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [3:0]  btn_in = '0;
  logic [15:0] pos_a_x = '0, pos_a_y = '0, pos_b_x = '0, pos_b_y = '0;
  logic        pos_a_rdy = 1'b0, pos_b_rdy = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic        m_mode;
  logic [5:0]  m_ien, m_evt;
  logic [3:0]  m_pol, m_btn;
  logic [15:0] m_x [2];
  logic [15:0] m_y [2];

  always #2.5 clk = ~clk;

  gameport_irq_ctrl u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic brd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  function automatic logic exp_irq();
    return m_mode & (|(m_evt & m_ien));
  endfunction

  task automatic check_state(input string req);
    logic [7:0] d;
    brd(4'h2, d);
    chk({req, " status"}, {24'd0, d}, {26'd0, m_evt});
    @(negedge clk);
    chk({req, " irq"}, {31'd0, irq}, {31'd0, exp_irq()});
  endtask

  task automatic set_btn(input int i, input logic v);
    @(negedge clk); btn_in[i] = v;
    if (m_btn[i] != v && m_mode && v == m_pol[i]) m_evt[i] = 1'b1;
    m_btn[i] = v;
    repeat (5) @(negedge clk);
  endtask

  task automatic strobe(input int dv, input logic [15:0] x, input logic [15:0] y);
    @(negedge clk);
    if (dv == 0) begin pos_a_x = x; pos_a_y = y; pos_a_rdy = 1'b1; end
    else         begin pos_b_x = x; pos_b_y = y; pos_b_rdy = 1'b1; end
    @(negedge clk);
    pos_a_rdy = 1'b0; pos_b_rdy = 1'b0;
    pos_a_x = $urandom; pos_a_y = $urandom; pos_b_x = $urandom; pos_b_y = $urandom;
    m_x[dv] = x; m_y[dv] = y;
    if (m_mode) m_evt[4+dv] = 1'b1;
  endtask

  task automatic check_pos();
    logic [7:0] d;
    for (int a = 8; a < 16; a++) begin
      logic [15:0] w;
      w = a[1] ? m_y[a[2]] : m_x[a[2]];
      brd(4'(a), d);
      chk("R10 position byte", {24'd0, d}, {24'd0, a[0] ? w[15:8] : w[7:0]});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5EED_0042));
    m_mode = 0; m_ien = 0; m_evt = 0; m_pol = 0; m_btn = 0;
    m_x[0] = 0; m_x[1] = 0; m_y[0] = 0; m_y[1] = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 rdata", {24'd0, bus_rdata}, 0);
    for (int a = 0; a < 16; a++) begin
      brd(4'(a), d);
      chk("R1 register", {24'd0, d}, 0);
    end

    // R2 control register
    bwr(4'h0, 8'hFF); brd(4'h0, d);
    chk("R2 mode set", {24'd0, d}, 32'h01);
    bwr(4'h0, 8'hFE); brd(4'h0, d);
    chk("R2 mode clear", {24'd0, d}, 32'h00);

    // R3 live levels, write ignored
    btn_in = 4'b1010; m_btn = 4'b1010;
    repeat (4) @(negedge clk);
    bwr(4'h1, 8'h05); brd(4'h1, d);
    chk("R3 live levels", {24'd0, d}, 32'h0A);

    // R9 legacy: edges and strobes do not latch, irq low
    bwr(4'h3, 8'h3F); m_ien = 6'h3F;
    bwr(4'h4, 8'h0F); m_pol = 4'hF;
    set_btn(0, 1'b1);
    strobe(0, 16'h1234, 16'h5678);
    check_state("R9 legacy");

    // R4 / R5 / R8 in enhanced mode
    bwr(4'h0, 8'h01); m_mode = 1;
    bwr(4'h3, 8'h00); m_ien = 0;
    set_btn(2, 1'b1);
    check_state("R4 rising edge");
    bwr(4'h4, 8'h00); m_pol = 0;
    set_btn(1, 1'b0);
    check_state("R4 falling edge");
    strobe(1, 16'hBEEF, 16'hCAFE);
    check_state("R5 device B ready");
    check_pos();

    bwr(4'h3, 8'h20); m_ien = 6'h20;
    repeat (10) @(negedge clk);
    check_state("R8 level held");
    bwr(4'h2, 8'h00);
    check_state("R6 zero write keeps");
    bwr(4'h2, 8'h20); m_evt[5] = 0;
    check_state("R8 cleared");

    // R7 event and clear in the same cycle
    @(negedge clk);
    pos_a_rdy = 1'b1; pos_a_x = 16'h0F0F; pos_a_y = 16'hA5A5;
    bus_addr = 4'h2; bus_wdata = 8'h10; bus_wr = 1'b1;
    @(negedge clk);
    pos_a_rdy = 1'b0; bus_wr = 1'b0;
    m_evt[4] = 1; m_x[0] = 16'h0F0F; m_y[0] = 16'hA5A5;
    check_state("R7 event wins");
    check_pos();

    // R11 unused offsets
    for (int a = 5; a < 8; a++) begin
      brd(4'(a), d);
      chk("R11 unused offset", {24'd0, d}, 0);
    end

    // constrained random mix
    for (int it = 0; it < 300; it++) begin
      int op;
      op = $urandom % 8;
      case (op)
        0, 1: set_btn($urandom % 4, 1'($urandom));
        2: strobe($urandom % 2, 16'($urandom), 16'($urandom));
        3: begin logic [7:0] v; v = 8'($urandom); bwr(4'h2, v); m_evt = m_evt & ~v[5:0]; end
        4: begin logic [7:0] v; v = 8'($urandom); bwr(4'h3, v); m_ien = v[5:0]; end
        5: begin logic [7:0] v; v = 8'($urandom); bwr(4'h4, v); m_pol = v[3:0]; end
        6: begin logic [7:0] v; v = 8'($urandom % 5 == 0 ? 0 : 1); bwr(4'h0, v); m_mode = v[0]; end
        default: begin
          brd(4'h1, d);
          chk("R3 live random", {24'd0, d}, {28'd0, m_btn});
        end
      endcase
      check_state("R4 R5 R6 R8 R9 random");
      if (it % 50 == 0) check_pos();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule